// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns one 64-bit interrupt request word, issued by a core, into per-core pending bits for the software-generated interrupt (SGI) number carried in that word. The word selects one of two delivery modes. In broadcast mode every core except the issuing core is signalled. In targeted mode a core is signalled when its three upper affinity bytes equal the ones in the word and its lowest affinity byte selects a set bit in a 16-bit target mask.

The dispatcher examines one core per clock, starting at core 0. It compares each core against a table of core affinities supplied on an input bus. In targeted mode it keeps a working copy of the mask and removes each signalled core's bit from it. The scan stops as soon as that copy is empty. When the scan ends the block raises a done pulse. If at least one core was signalled, it also raises a state-update pulse in the same cycle and a wake pulse one cycle later. Pending bits record only the SGI number per target core and never the sender. A consumer clears one bit at a time through a clear port. A request is accepted only while the block is idle, and `req_ready` holds off any request that arrives during a scan.

Top module: `sgi_dispatch`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `pend_o`, `done_o`, `upd_o` and `wake_o` are all 0.
- R2: Request word fields are as follows. Target mask is bits 15:0. Affinity byte 1 is bits 23:16. SGI number is bits 27:24. Affinity byte 2 is bits 39:32. The broadcast flag is bit 40. Affinity byte 3 is bits 55:48. Every other bit has no effect.
- R3: With the broadcast flag set, the bit for the SGI number is set on every core whose index differs from `req_core`, and on no other core.
- R4: With the broadcast flag clear, a core is signalled only if affinity bytes 3, 2 and 1 of its table entry (bits 31:24, 23:16, 15:8) equal the request's, and the mask bit indexed by its affinity byte 0 (bits 7:0) is set. A core whose byte 0 is 16 or more is never signalled.
- R5: Cores are examined in index order, one per clock. A broadcast examines all `N_CORES` cores. A targeted scan ends after the core whose match empties the working mask, or after the last core. `done_o` is high for exactly one cycle, in the cycle after the clock edge that examines the final core.
- R6: `upd_o` is high together with `done_o` exactly when at least one core was signalled. `wake_o` is high in the following cycle, and only then.
- R7: `req_ready` falls after a request is accepted and stays low until the done cycle, when it is high again. A request presented while `req_ready` is low is neither accepted nor acted on.
- R8: Pending bit `core*16 + sgi` of `pend_o` is set by a dispatch and keeps its value until a clear. A clear on (`clr_core`, `clr_sgi`) zeroes exactly that bit at the next clock edge and leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word present |
| req_ready | output | 1 | Dispatcher idle, request will be taken |
| req_word | input | 64 | Request word (fields per R2) |
| req_core | input | $clog2(N_CORES) | Index of the issuing core |
| core_aff | input | N_CORES*32 | Affinity table, 32 bits per core: byte3, byte2, byte1, byte0 |
| clr_valid | input | 1 | Clear one pending bit |
| clr_core | input | $clog2(N_CORES) | Core of the bit to clear |
| clr_sgi | input | 4 | SGI number of the bit to clear |
| pend_o | output | N_CORES*16 | Pending bits, index core*16+sgi |
| done_o | output | 1 | Scan finished (one cycle) |
| upd_o | output | 1 | State-update pulse, at least one core signalled |
| wake_o | output | 1 | Wake pulse, one cycle after `upd_o` |

## Verification
The request is taken on a clock edge. A pending bit appears on the edge that examines its core. `done_o` and `upd_o` appear in the cycle after the edge that examines the last core, and `wake_o` one cycle later. A clear takes effect one edge after it is driven. For each request the bench computes the expected number of scan edges from the affinity table and the mask, counts edges from acceptance until `done_o` is seen, and requires the two counts to match. Pending bits and `upd_o` are compared in that done cycle, `wake_o` one cycle later, and `req_ready` at every falling edge of the scan. All sampling happens on falling clock edges.

// File: rtl/sgi_disp_pkg.sv
package sgi_disp_pkg;

    localparam int TLIST_W    = 16;
    localparam int TL_IW      = $clog2(TLIST_W);
    localparam int AFF_W      = 8;
    localparam int CORE_AFF_W = 4 * AFF_W;
    localparam int SGI_ID_W   = 4;
    localparam int SGI_NUM    = 1 << SGI_ID_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    // Decoded request held for the duration of a scan
    typedef struct packed {
        logic [SGI_ID_W-1:0] sgi;
        logic                bcast;
        logic [TLIST_W-1:0]  tlist;
        logic [AFF_W-1:0]    aff3;
        logic [AFF_W-1:0]    aff2;
        logic [AFF_W-1:0]    aff1;
    } sgi_req_t;

endpackage

// File: rtl/sgi_core_match.sv
module sgi_core_match
    import sgi_disp_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                  bcast,
    input  logic [TLIST_W-1:0]    tlist,
    input  logic [AFF_W-1:0]      aff3,
    input  logic [AFF_W-1:0]      aff2,
    input  logic [AFF_W-1:0]      aff1,
    input  logic [CORE_AFF_W-1:0] aff,
    input  logic [IDX_W-1:0]      core_idx,
    input  logic [IDX_W-1:0]      src_idx,
    output logic                  hit,
    output logic [TLIST_W-1:0]    consume
);
    logic [AFF_W-1:0]   a0;
    logic [TLIST_W-1:0] tbit;
    logic               upper_eq;
    logic               tgt_hit;

    always_comb begin
        a0       = aff[AFF_W-1:0];
        tbit     = '0;
        if (a0 < AFF_W'(TLIST_W)) begin
            tbit = TLIST_W'(1) << a0[TL_IW-1:0];
        end
        upper_eq = (aff[4*AFF_W-1:3*AFF_W] == aff3) &&
                   (aff[3*AFF_W-1:2*AFF_W] == aff2) &&
                   (aff[2*AFF_W-1:AFF_W]   == aff1);
        tgt_hit  = upper_eq && ((tlist & tbit) != '0);
        hit      = bcast ? (core_idx != src_idx) : tgt_hit;
        consume  = (!bcast && tgt_hit) ? tbit : '0;
    end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
    import sgi_disp_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [IDX_W-1:0]           set_core,
    input  logic [SGI_ID_W-1:0]        set_sgi,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_core,
    input  logic [SGI_ID_W-1:0]        clr_sgi,
    output logic [N_CORES*SGI_NUM-1:0] pend
);
    for (genvar g = 0; g < N_CORES; g++) begin : g_row
        logic [SGI_NUM-1:0] row_d, row_q;

        // A set arriving in the same cycle as a clear of the same bit wins
        always_comb begin
            row_d = row_q;
            if (clr_en && (clr_core == IDX_W'(g))) row_d[clr_sgi] = 1'b0;
            if (set_en && (set_core == IDX_W'(g))) row_d[set_sgi] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_d;
        end

        assign pend[g*SGI_NUM +: SGI_NUM] = row_q;
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_disp_pkg::*;
#(
    parameter  int N_CORES = 8,
    localparam int IDX_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [63:0]                   req_word,
    input  logic [IDX_W-1:0]              req_core,
    input  logic [N_CORES*CORE_AFF_W-1:0] core_aff,
    input  logic                          clr_valid,
    input  logic [IDX_W-1:0]              clr_core,
    input  logic [SGI_ID_W-1:0]           clr_sgi,
    output logic [N_CORES*SGI_NUM-1:0]    pend_o,
    output logic                          done_o,
    output logic                          upd_o,
    output logic                          wake_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CORES - 1);

    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] src;
        sgi_req_t         req;
        logic             hit;
        logic             done;
        logic             upd;
        logic             wake;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, idx: '0, src: '0, req: '0,
                                 hit: 1'b0, done: 1'b0, upd: 1'b0, wake: 1'b0};

    ctl_t                  d, q;
    sgi_req_t              in_req;
    logic [CORE_AFF_W-1:0] sel_aff;
    logic                  m_hit;
    logic [TLIST_W-1:0]    m_consume;
    logic                  set_en;
    logic                  unused_word_bits;

    // Request word field split; remaining bits carry no meaning here
    always_comb begin
        in_req.tlist = req_word[15:0];
        in_req.aff1  = req_word[23:16];
        in_req.sgi   = req_word[27:24];
        in_req.aff2  = req_word[39:32];
        in_req.bcast = req_word[40];
        in_req.aff3  = req_word[55:48];
    end
    assign unused_word_bits = ^{req_word[31:28], req_word[47:41], req_word[63:56]};

    assign sel_aff = core_aff[q.idx*CORE_AFF_W +: CORE_AFF_W];

    sgi_core_match #(.IDX_W(IDX_W)) u_match (
        .bcast    (q.req.bcast),
        .tlist    (q.req.tlist),
        .aff3     (q.req.aff3),
        .aff2     (q.req.aff2),
        .aff1     (q.req.aff1),
        .aff      (sel_aff),
        .core_idx (q.idx),
        .src_idx  (q.src),
        .hit      (m_hit),
        .consume  (m_consume)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.upd  = 1'b0;
        d.wake = q.upd;
        set_en = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st  = ST_SCAN;
                    d.idx = '0;
                    d.src = req_core;
                    d.req = in_req;
                    d.hit = 1'b0;
                end
            end
            ST_SCAN: begin
                set_en      = m_hit;
                d.req.tlist = q.req.tlist & ~m_consume;
                d.hit       = q.hit | m_hit;
                if ((q.idx == LAST_IDX) || (!q.req.bcast && (d.req.tlist == '0))) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.upd  = q.hit | m_hit;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    sgi_pend_bank #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_core (q.idx),
        .set_sgi  (q.req.sgi),
        .clr_en   (clr_valid),
        .clr_core (clr_core),
        .clr_sgi  (clr_sgi),
        .pend     (pend_o)
    );

    assign req_ready = (q.st == ST_IDLE);
    assign done_o    = q.done;
    assign upd_o     = q.upd;
    assign wake_o    = q.wake;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_disp_pkg::*;
#(
    parameter int N_CORES = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [N_CORES*SGI_NUM-1:0] pend_o,
    input logic                       done_o,
    input logic                       upd_o,
    input logic                       wake_o
);
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_upd_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> done_o);

    p_wake_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> wake_o);

    p_wake_only_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(upd_o));

    p_pend_rise_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend_o) > $countones($past(pend_o))) |-> !$past(req_ready));

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.N_CORES(N_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .pend_o    (pend_o),
    .done_o    (done_o),
    .upd_o     (upd_o),
    .wake_o    (wake_o)
);

// File: tb/tb_sgi_dispatch.sv
`timescale 1ns/1ps
module tb_sgi_dispatch;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [63:0]    req_word = '0;
    logic [IW-1:0]  req_core = '0;
    logic [N*32-1:0] core_aff = '0;
    logic           clr_valid = 1'b0;
    logic [IW-1:0]  clr_core = '0;
    logic [3:0]     clr_sgi = '0;
    logic [N*16-1:0] pend_o;
    logic           done_o, upd_o, wake_o;

    always #4 clk = ~clk;

    sgi_dispatch #(.N_CORES(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_word(req_word), .req_core(req_core), .core_aff(core_aff),
        .clr_valid(clr_valid), .clr_core(clr_core), .clr_sgi(clr_sgi),
        .pend_o(pend_o), .done_o(done_o), .upd_o(upd_o), .wake_o(wake_o)
    );

    int vec_cnt = 0;
    int bad_cnt = 0;
    logic [7:0] ta3 [N];
    logic [7:0] ta2 [N];
    logic [7:0] ta1 [N];
    logic [7:0] ta0 [N];
    logic [N*16-1:0] pmodel = '0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        vec_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_word(input logic [3:0] sgi, input bit bc, input logic [15:0] tl,
                                            input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] a3,
                                            input logic [18:0] junk);
        logic [63:0] w;
        w = '0;
        w[15:0]  = tl;
        w[23:16] = a1;
        w[27:24] = sgi;
        w[31:28] = junk[3:0];
        w[39:32] = a2;
        w[40]    = bc;
        w[47:41] = junk[10:4];
        w[55:48] = a3;
        w[63:56] = junk[18:11];
        return w;
    endfunction

    // Expected signalled cores and scan length, from R3/R4/R5
    task automatic model_req(input bit bc, input logic [15:0] tl, input logic [7:0] a1,
                             input logic [7:0] a2, input logic [7:0] a3, input int src,
                             output logic [N-1:0] mask, output int n);
        logic [15:0] rem;
        bit m;
        rem = tl; mask = '0; n = 0;
        for (int c = 0; c < N; c++) begin
            n++;
            if (bc) m = (c != src);
            else m = (ta3[c] == a3) && (ta2[c] == a2) && (ta1[c] == a1) &&
                     (ta0[c] < 16) && rem[ta0[c][3:0]];
            if (m) begin
                mask[c] = 1'b1;
                if (!bc) rem[ta0[c][3:0]] = 1'b0;
            end
            if (!bc && rem == '0) break;
        end
    endtask

    task automatic run_req(input logic [3:0] sgi, input bit bc, input logic [15:0] tl,
                           input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] a3,
                           input int src, input logic [18:0] junk, input bit noise,
                           input string tag, output logic [N-1:0] mask);
        int n;
        int cyc;
        bit seen;
        bit busy_err;
        model_req(bc, tl, a1, a2, a3, src, mask, n);
        for (int c = 0; c < N; c++) if (mask[c]) pmodel[c*16 + int'(sgi)] = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready while idle", 128'(req_ready), 128'(1));
        req_valid = 1'b1;
        req_word  = mk_word(sgi, bc, tl, a1, a2, a3, junk);
        req_core  = IW'(src);
        @(posedge clk);
        @(negedge clk);
        busy_err = req_ready;
        if (noise) begin
            req_word = mk_word(sgi ^ 4'h1, 1'b1, 16'hFFFF, 8'h0, 8'h0, 8'h0, 19'h0);
            req_core = IW'((src + 1) % N);
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0; seen = 0;
        while (!seen && cyc < 64) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done_o) seen = 1;
            else if (req_ready) busy_err = 1;
        end
        req_valid = 1'b0;
        chk(seen && cyc == n, "R5 scan length", 128'(cyc), 128'(n));
        chk(pend_o == pmodel, tag, pend_o, pmodel);
        chk(upd_o == (mask != '0), "R6 update pulse", 128'(upd_o), 128'(mask != '0));
        chk(req_ready && !busy_err, "R7 ready low only while busy", 128'({busy_err, req_ready}), 128'(1));
        @(posedge clk);
        @(negedge clk);
        chk(wake_o == (mask != '0) && !upd_o && !done_o, "R6 wake follows update",
            128'({wake_o, upd_o, done_o}), 128'({(mask != '0), 2'b00}));
    endtask

    task automatic clr_bit(input int c, input int s);
        @(negedge clk);
        clr_valid = 1'b1;
        clr_core  = IW'(c);
        clr_sgi   = 4'(s);
        @(posedge clk);
        @(negedge clk);
        clr_valid = 1'b0;
        pmodel[c*16 + s] = 1'b0;
        chk(pend_o == pmodel, "R8 clear single bit", pend_o, pmodel);
    endtask

    task automatic clr_mask(input logic [N-1:0] mask, input int s);
        for (int c = 0; c < N; c++) if (mask[c]) clr_bit(c, s);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vec_cnt++;
        bad_cnt++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [N-1:0] mk;
        logic [7:0] g3 [4];
        logic [7:0] g2 [4];
        logic [7:0] g1 [4];
        // Affinity table {byte3, byte2, byte1, byte0}
        ta3 = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'd0};
        ta2 = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd0};
        ta1 = '{8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0};
        ta0 = '{8'd0, 8'd1, 8'd3, 8'd0, 8'd2, 8'd20, 8'd5, 8'd15};
        for (int c = 0; c < N; c++) core_aff[c*32 +: 32] = {ta3[c], ta2[c], ta1[c], ta0[c]};
        g3 = '{8'd0, 8'd0, 8'd2, 8'd0};
        g2 = '{8'd0, 8'd0, 8'd1, 8'd1};
        g1 = '{8'd0, 8'd1, 8'd0, 8'd0};

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 128'(req_ready), 128'(1));
        chk(pend_o == '0 && !done_o && !upd_o && !wake_o, "R1 outputs in reset",
            128'({pend_o, done_o, upd_o, wake_o}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && pend_o == '0 && !done_o && !upd_o && !wake_o, "R1 state after reset",
            128'({req_ready, pend_o, done_o, upd_o, wake_o}), 128'(1) << 131);

        // R2: all ignored bits set, targeted at core 4
        run_req(4'd6, 1'b0, 16'h0004, 8'd1, 8'd0, 8'd0, 0, 19'h7FFFF, 1'b0, "R2 ignored bits", mk);
        clr_mask(mk, 6);

        // R8 accumulation, with R7 busy stimulus during the first scan
        run_req(4'd3, 1'b1, 16'h0000, 8'd0, 8'd0, 8'd0, 0, 19'h0, 1'b1, "R3 broadcast with busy request", mk);
        run_req(4'd9, 1'b0, 16'h0002, 8'd0, 8'd0, 8'd0, 5, 19'h1234, 1'b0, "R8 accumulate", mk);
        chk(pend_o == pmodel, "R8 earlier bits kept", pend_o, pmodel);
        for (int b = 0; b < N*16; b++) if (pmodel[b]) clr_bit(b / 16, b % 16);
        chk(pend_o == '0, "R8 all cleared", pend_o, 128'(0));

        // R3: broadcast sweep over requester and SGI number
        for (int s = 0; s < N; s++) begin
            for (int id = 0; id < 16; id++) begin
                run_req(4'(id), 1'b1, 16'(s * 4099 + id), 8'(id), 8'(s), 8'd0, s, 19'(id * 7919),
                        (id % 2) == 1, "R3 broadcast pending", mk);
                clr_mask(mk, id);
            end
        end

        // R4/R5: targeted sweep over affinity groups and target masks
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < 256; i++) begin
                logic [15:0] tl;
                tl = {i[7], 8'h00, i[6:0]};
                run_req(4'(i % 16), 1'b0, tl, g1[g], g2[g], g3[g], i % N, 19'(i * 131 + g),
                        (i % 5) == 0, "R4 targeted pending", mk);
                clr_mask(mk, i % 16);
            end
        end

        // R4: unreachable byte0 and empty mask
        run_req(4'd2, 1'b0, 16'hFFFF, 8'd1, 8'd0, 8'd0, 0, 19'h0, 1'b0, "R4 byte0 above 15", mk);
        clr_mask(mk, 2);
        run_req(4'd1, 1'b0, 16'h0000, 8'd0, 8'd0, 8'd0, 0, 19'h0, 1'b0, "R4 empty mask", mk);
        chk(mk == '0, "R5 empty mask signals nobody", 128'(mk), 128'(0));

        finish_run();
    end

endmodule